// File: doc/BRIEF.md
# Interrupt Enable Set/Clear Gate

This block decides which of a host controller's event sources may raise the single interrupt request seen by the system interrupt manager. It holds one enable bit per source and one master enable. Software never writes the enable word directly. Instead it uses two register addresses on a small register bus:

- At the set address, every data bit written as 1 turns the matching enable on.
- At the clear address, every data bit written as 1 turns the matching enable off.

In both cases a 0 bit leaves the matching enable as it was.

Raw status lines come from the controller's event logic. The block ANDs each status line with its enable and ORs the results together. It then qualifies that OR with the master enable and registers the outcome once to form the request. A single bus write targets one address only, so one cycle can never both set and clear the same bit.

Top module: `irq_en_ctrl`

## Requirements
- R1: A write to the set address (default 0x10) turns on every enable whose data bit is 1, and leaves every enable whose data bit is 0 unchanged.
- R2: A write to the clear address (default 0x14) turns off every enable whose data bit is 1, and leaves every enable whose data bit is 0 unchanged.
- R3: `irq_req` equals master enable AND (OR over sources of status AND enable), sampled at one rising clock edge and visible after that edge. A source whose own enable is 0, or any source while the master enable is 0, cannot raise it.
- R4: The data bit positions of the sources are: bit 0 scheduling overrun, bit 1 write-done-head, bit 2 start of frame, bit 3 resume detect, bit 4 unrecoverable error, bit 5 frame number overflow, bit 6 root hub status change. Status line i maps to data bit i. The master enable is at bit 31.
- R5: A read of the clear address returns all zeros.
- R6: A read of the set address returns the source enables at bits 0..6 and the master enable at bit 31. Bits 30 and 29..7 read as 0, and writing bit 30 at either address changes nothing.
- R7: While reset is asserted, all enables and `irq_req` are 0.
- R8: A write to any address other than the set and clear addresses leaves all enables unchanged.
- R9: While `bus_rd` is low, `bus_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | ADDR_W (8) | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, combinational from address and strobe |
| src_status | input | N_SRC (7) | Raw event status lines, bit i is source i |
| irq_req | output | 1 | Registered interrupt request |

## Verification
A wrong enable bit is visible in two places. It shows on `bus_rdata` as soon as the set address is read. It also shows on `irq_req` one edge after the matching status line is raised. The random phase reads the set address after every operation and checks `irq_req` on every cycle. A corrupted set, clear or master bit is therefore reported within the same operation that caused it. The directed walk through each bit position catches a swapped or shifted mapping between a status line and its enable.

// File: rtl/irq_gate_pkg.sv
package irq_gate_pkg;
   localparam int unsigned REG_W      = 32;
   localparam int unsigned MASTER_POS = 31;
   localparam int unsigned OWNER_POS  = 30;

   typedef enum logic [1:0] {
      ACC_NONE  = 2'd0,
      ACC_SET   = 2'd1,
      ACC_CLR   = 2'd2,
      ACC_OTHER = 2'd3
   } acc_kind_e;
endpackage

// File: rtl/irq_bus_decode.sv
module irq_bus_decode #(
   parameter int unsigned ADDR_W   = 8,
   parameter logic [ADDR_W-1:0] SET_ADDR = 8'h10,
   parameter logic [ADDR_W-1:0] CLR_ADDR = 8'h14
) (
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   output logic              set_we,
   output logic              clr_we,
   output logic              rd_view
);
   import irq_gate_pkg::*;

   acc_kind_e kind;

   always_comb begin
      if (bus_addr == SET_ADDR)      kind = ACC_SET;
      else if (bus_addr == CLR_ADDR) kind = ACC_CLR;
      else                           kind = ACC_OTHER;
   end

   assign set_we  = bus_wr && (kind == ACC_SET);
   assign clr_we  = bus_wr && (kind == ACC_CLR);
   // only the set address exposes state; clear address and others read zero
   assign rd_view = bus_rd && (kind == ACC_SET);
endmodule

// File: rtl/irq_enable_bank.sv
module irq_enable_bank #(
   parameter int unsigned N_SRC = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             set_we,
   input  logic             clr_we,
   input  logic [N_SRC-1:0] src_wbits,
   input  logic             master_wbit,
   output logic [N_SRC-1:0] src_en,
   output logic             master_en
);
   localparam int unsigned N_BITS = N_SRC + 1;

   logic [N_BITS-1:0] wbits;
   logic [N_BITS-1:0] en_q;

   assign wbits = {master_wbit, src_wbits};

   for (genvar g = 0; g < N_BITS; g++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                    en_q[g] <= 1'b0;
         else if (set_we && wbits[g])   en_q[g] <= 1'b1;
         else if (clr_we && wbits[g])   en_q[g] <= 1'b0;
      end
   end

   assign src_en    = en_q[N_SRC-1:0];
   assign master_en = en_q[N_BITS-1];
endmodule

// File: rtl/irq_out_gate.sv
module irq_out_gate #(
   parameter int unsigned N_SRC = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] status,
   input  logic [N_SRC-1:0] src_en,
   input  logic             master_en,
   output logic             irq
);
   logic any_hit;
   logic irq_q;

   assign any_hit = |(status & src_en);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= master_en & any_hit;
   end

   assign irq = irq_q;
endmodule

// File: rtl/irq_en_ctrl.sv
module irq_en_ctrl #(
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned N_SRC    = 7,
   parameter logic [ADDR_W-1:0] SET_ADDR = 8'h10,
   parameter logic [ADDR_W-1:0] CLR_ADDR = 8'h14
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [ADDR_W-1:0]             bus_addr,
   input  logic [irq_gate_pkg::REG_W-1:0] bus_wdata,
   input  logic                          bus_wr,
   input  logic                          bus_rd,
   output logic [irq_gate_pkg::REG_W-1:0] bus_rdata,
   input  logic [N_SRC-1:0]              src_status,
   output logic                          irq_req
);
   import irq_gate_pkg::*;

   if (N_SRC < 1 || N_SRC > OWNER_POS) begin : g_bad_nsrc
      $error("irq_en_ctrl: N_SRC must lie in 1..%0d", OWNER_POS);
   end
   if (SET_ADDR == CLR_ADDR) begin : g_bad_addr
      $error("irq_en_ctrl: set and clear addresses must differ");
   end

   logic             set_we, clr_we, rd_view;
   logic [N_SRC-1:0] src_en;
   logic             master_en;
   logic [REG_W-1:0] view;
   logic             wdata_unused;

   // bit 30 and the reserved span carry no function
   assign wdata_unused = ^bus_wdata[OWNER_POS:N_SRC];

   irq_bus_decode #(
      .ADDR_W  (ADDR_W),
      .SET_ADDR(SET_ADDR),
      .CLR_ADDR(CLR_ADDR)
   ) u_dec (
      .bus_wr  (bus_wr),
      .bus_rd  (bus_rd),
      .bus_addr(bus_addr),
      .set_we  (set_we),
      .clr_we  (clr_we),
      .rd_view (rd_view)
   );

   irq_enable_bank #(.N_SRC(N_SRC)) u_bank (
      .clk        (clk),
      .rst_n      (rst_n),
      .set_we     (set_we),
      .clr_we     (clr_we),
      .src_wbits  (bus_wdata[N_SRC-1:0]),
      .master_wbit(bus_wdata[MASTER_POS]),
      .src_en     (src_en),
      .master_en  (master_en)
   );

   irq_out_gate #(.N_SRC(N_SRC)) u_gate (
      .clk      (clk),
      .rst_n    (rst_n),
      .status   (src_status),
      .src_en   (src_en),
      .master_en(master_en),
      .irq      (irq_req)
   );

   always_comb begin
      view                 = '0;
      view[N_SRC-1:0]      = src_en;
      view[MASTER_POS]     = master_en;
   end

   assign bus_rdata = rd_view ? view : '0;
endmodule

// File: rtl/irq_en_ctrl_chk.sv
module irq_en_ctrl_chk #(
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned N_SRC    = 7,
   parameter logic [ADDR_W-1:0] SET_ADDR = 8'h10,
   parameter logic [ADDR_W-1:0] CLR_ADDR = 8'h14
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [31:0]       bus_wdata,
   input logic              bus_wr,
   input logic              bus_rd,
   input logic [31:0]       bus_rdata,
   input logic [N_SRC-1:0]  src_status,
   input logic              irq_req,
   input logic [N_SRC-1:0]  src_en,
   input logic              master_en
);
   logic [N_SRC:0] en_cat;
   logic [N_SRC:0] w_sel;
   logic           is_set, is_clr;

   assign en_cat = {master_en, src_en};
   assign w_sel  = {bus_wdata[31], bus_wdata[N_SRC-1:0]};
   assign is_set = bus_wr && (bus_addr == SET_ADDR);
   assign is_clr = bus_wr && (bus_addr == CLR_ADDR);

   assert_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
      is_set |=> ((en_cat & $past(w_sel)) == $past(w_sel)) && (($past(en_cat) & ~en_cat) == '0));

   assert_clr_R2: assert property (@(posedge clk) disable iff (!rst_n)
      is_clr |=> ((en_cat & $past(w_sel)) == '0) && ((en_cat & ~$past(en_cat)) == '0));

   assert_irq_R3: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (irq_req == $past(master_en && (|(src_status & src_en)))));

   assert_clr_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr == CLR_ADDR) |-> (bus_rdata == '0));

   assert_reserved_R6: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rdata[30:N_SRC] == '0);

   assert_reset_R7: assert property (@(posedge clk)
      !rst_n |=> (en_cat == '0) && !irq_req);

   assert_other_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && !is_set && !is_clr) |=> (en_cat == $past(en_cat)));

   assert_idle_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |-> (bus_rdata == '0));
endmodule

bind irq_en_ctrl irq_en_ctrl_chk #(
   .ADDR_W  (ADDR_W),
   .N_SRC   (N_SRC),
   .SET_ADDR(SET_ADDR),
   .CLR_ADDR(CLR_ADDR)
) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .bus_wr    (bus_wr),
   .bus_rd    (bus_rd),
   .bus_rdata (bus_rdata),
   .src_status(src_status),
   .irq_req   (irq_req),
   .src_en    (src_en),
   .master_en (master_en)
);

// File: tb/test_irq_en_ctrl.sv
module test_irq_en_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam int N          = 7;
   localparam logic [7:0] A_SET = 8'h10;
   localparam logic [7:0] A_CLR = 8'h14;
   localparam logic [31:0] FUNC_MASK = 32'h8000_007F;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [31:0] bus_rdata;
   logic [N-1:0] src_status = '0;
   logic        irq_req;

   logic [31:0] en_m = '0;
   logic        exp_irq = 1'b0;
   int          n_chk = 0;
   int          n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   irq_en_ctrl i_irq_en_ctrl (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
      .src_status(src_status), .irq_req(irq_req)
   );

   function automatic logic [31:0] next_en(logic [31:0] en, logic wr,
                                           logic [7:0] a, logic [31:0] d);
      if (wr && a == A_SET) return en | (d & FUNC_MASK);
      if (wr && a == A_CLR) return en & ~(d & FUNC_MASK);
      return en;
   endfunction

   function automatic logic calc_irq(logic [31:0] en, logic [N-1:0] st);
      return en[31] & (|(st & en[N-1:0]));
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h time=%0t", req, act, exp, $time);
      end
   endtask

   task automatic step();
      logic [31:0] nen;
      logic        nirq;
      nirq = calc_irq(en_m, src_status);
      nen  = next_en(en_m, bus_wr, bus_addr, bus_wdata);
      @(posedge clk); #1;
      en_m = nen; exp_irq = nirq;
      chk("R3 irq", {31'd0, irq_req}, {31'd0, exp_irq});
   endtask

   task automatic wr(logic [7:0] a, logic [31:0] d);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      step();
      bus_wr = 1'b0; bus_wdata = '0;
   endtask

   task automatic rd_chk(string req, logic [7:0] a, logic [31:0] exp);
      bus_addr = a; bus_rd = 1'b1; #1;
      chk(req, bus_rdata, exp);
      bus_rd = 1'b0; #1;
      chk("R9 idle read", bus_rdata, 32'd0);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'd4711));
      repeat (3) @(posedge clk);
      #1;
      chk("R7 reset irq", {31'd0, irq_req}, 32'd0);
      rd_chk("R7 reset enables", A_SET, 32'd0);
      rst_n = 1'b1;
      step();

      // R3: enabled source without master stays blocked
      src_status = 7'b000_0100;
      wr(A_SET, 32'h0000_0004);
      step(); chk("R3 no master", {31'd0, irq_req}, 32'd0);
      wr(A_SET, 32'h8000_0000);
      step(); chk("R3 master on", {31'd0, irq_req}, 32'd1);
      rd_chk("R1 set readback", A_SET, 32'h8000_0004);
      // R1: zero write changes nothing
      wr(A_SET, 32'h0);
      rd_chk("R1 zero write", A_SET, 32'h8000_0004);
      // R6: bit 30 and reserved bits ignored
      wr(A_SET, 32'h7FFF_FF80);
      rd_chk("R6 reserved", A_SET, 32'h8000_0004);
      wr(A_CLR, 32'h4000_0000);
      rd_chk("R6 owner clear", A_SET, 32'h8000_0004);
      // R5: clear address reads zero
      rd_chk("R5 clear read", A_CLR, 32'd0);
      // R8: other address write ignored
      wr(8'h18, 32'hFFFF_FFFF);
      wr(8'h00, 32'hFFFF_FFFF);
      rd_chk("R8 other addr", A_SET, 32'h8000_0004);
      // R2: clear the source, irq drops
      wr(A_CLR, 32'h0000_0004);
      step(); chk("R2 irq drop", {31'd0, irq_req}, 32'd0);
      rd_chk("R2 clear readback", A_SET, 32'h8000_0000);
      wr(A_CLR, 32'h0);
      rd_chk("R2 zero write", A_SET, 32'h8000_0000);

      // R4: walk each source position alone
      for (int i = 0; i < N; i++) begin
         wr(A_CLR, 32'h0000_007F);
         src_status = 7'(1 << i);
         wr(A_SET, 32'h1 << i);
         step(); chk("R4 bit irq", {31'd0, irq_req}, 32'd1);
         rd_chk("R4 bit pos", A_SET, 32'h8000_0000 | (32'h1 << i));
         src_status = ~7'(1 << i);
         step(); step();
         chk("R4 other src blocked", {31'd0, irq_req}, 32'd0);
      end
      // master clear blocks everything
      src_status = '1;
      wr(A_SET, 32'h0000_007F);
      wr(A_CLR, 32'h8000_0000);
      step(); chk("R3 master off", {31'd0, irq_req}, 32'd0);

      // random mix
      for (int k = 0; k < 400; k++) begin
         int unsigned op;
         logic [7:0]  a;
         op = $urandom_range(0, 9);
         src_status = 7'($urandom);
         if (op < 4)      a = A_SET;
         else if (op < 8) a = A_CLR;
         else             a = 8'($urandom);
         if (op == 9 && $urandom_range(0, 1) == 1) step();
         else wr(a, $urandom);
         rd_chk("R1 R2 R8 random readback", A_SET, en_m);
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule